// File: doc/BRIEF.md
# Packed-Integer Absolute Difference and Accumulate Unit

This block is a one-stage vector datapath for 128-bit registers. Each lane of the result holds the magnitude of the difference between the matching lanes of two source vectors, `src_a` minus `src_b`. An optional accumulate step adds that magnitude to the matching lane of a third vector, `acc_in`. Lane values can be read as unsigned numbers or as two's-complement numbers.

A widening form is also available. It reads narrow lanes from one 64-bit half of the sources and extends each lane to twice its width before the subtraction, so the difference can never overflow. It then writes lanes of double width across the full 128-bit result. The caller picks which source half to read.

Operands and controls are presented together with a valid strobe. The result and an illegal-size flag appear one clock later, together with a delayed valid.

Top module: `simd_absdiff_acc`

## Requirements
- R1: With `op_acc`=0, `widen`=0 and `is_signed`=0, each result lane equals |a−b|, where a and b are the matching `src_a` and `src_b` lanes read as unsigned numbers. Lane i occupies bits [i*W+W-1 : i*W].
- R2: With `is_signed`=1, the lanes are read as two's-complement numbers. For example, 8-bit lanes 0x80 and 0x7F give 0xFF, while the same lanes read as unsigned give 0x01.
- R3: With `op_acc`=1, each result lane equals the matching `acc_in` lane plus the absolute difference, taken modulo 2^W, where W is the result lane width.
- R4: In non-widening mode, `lane_sz` sets the lane width: 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits. With `full_width`=1 all 128 bits carry lanes.
- R5: In non-widening mode with `full_width`=0, only bits 63:0 carry lanes. Result bits 127:64 are zero whatever `src_a`, `src_b` and `acc_in` hold there.
- R6: With `widen`=1, source lanes of 8, 16 or 32 bits (`lane_sz` 0, 1 or 2) are sign- or zero-extended according to `is_signed`. Each gives a 16-, 32- or 64-bit result lane equal to the exact magnitude of the difference. `full_width` has no effect in this mode.
- R7: In widening mode, `upper_half`=1 takes the source lanes from bits 127:64 of `src_a` and `src_b`. `upper_half`=0 takes them from bits 63:0.
- R8: A widening accumulate adds the extended magnitude to the double-width `acc_in` lane, taken modulo 2^(2·source width).
- R9: `out_valid` equals `in_valid` delayed by one clock. `result` and `illegal` change only in the clock after an `in_valid` cycle and hold their values otherwise.
- R10: `lane_sz`=3, in either mode, sets `illegal` to 1 and gives a zero result. A valid legal operation clears `illegal`.
- R11: While reset is asserted, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls valid this cycle |
| src_a | input | 128 | Minuend vector |
| src_b | input | 128 | Subtrahend vector |
| acc_in | input | 128 | Accumulator vector |
| op_acc | input | 1 | 1: accumulate, 0: plain difference |
| is_signed | input | 1 | 1: two's-complement lanes |
| lane_sz | input | 2 | Source lane width code (0: 8, 1: 16, 2: 32, 3: illegal) |
| full_width | input | 1 | Non-widening: 1 selects 128-bit, 0 selects 64-bit arrangement |
| widen | input | 1 | Widening form |
| upper_half | input | 1 | Widening: read sources from bits 127:64 |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Result vector |
| illegal | output | 1 | Last accepted operation had an unsupported lane size |

## Verification
All state sits in one output register, so any fault shows at the ports in the clock after the offending valid cycle.

A wrong extension bit or a wrong sign choice shows up only on lanes whose operands straddle the sign boundary. A mis-steered half or a missing upper mask shows up only when the unused source half or accumulator half carries non-zero data. The stimulus is therefore built so that these unused regions are never quiet.

// File: rtl/simd_abd_pkg.sv
package simd_abd_pkg;
  localparam int VEC_W  = 128;
  localparam int HALF_W = VEC_W / 2;
  localparam int NUM_SZ = 3;

  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_B16 = 2'd1,
    LANE_B32 = 2'd2,
    LANE_BAD = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/abd_lane_bank.sv
module abd_lane_bank #(
  parameter int SRC_W = 8,
  parameter int DST_W = 8,
  parameter int LANES = 16
) (
  input  logic [LANES*SRC_W-1:0] src_a,
  input  logic [LANES*SRC_W-1:0] src_b,
  input  logic [LANES*DST_W-1:0] acc_in,
  input  logic                   is_signed,
  input  logic                   op_acc,
  output logic [LANES*DST_W-1:0] lane_res
);
  // magnitude of x-y with one guard bit; always fits SRC_W unsigned bits
  function automatic logic [SRC_W-1:0] abs_diff(input logic [SRC_W-1:0] x,
                                               input logic [SRC_W-1:0] y,
                                               input logic sg);
    logic [SRC_W:0] xe, ye, d;
    xe = {sg & x[SRC_W-1], x};
    ye = {sg & y[SRC_W-1], y};
    d  = xe - ye;
    if (d[SRC_W]) d = -d;
    return d[SRC_W-1:0];
  endfunction

  function automatic logic [DST_W-1:0] fold_acc(input logic [SRC_W-1:0] mag,
                                               input logic [DST_W-1:0] acc,
                                               input logic en);
    logic [DST_W-1:0] ext;
    ext = DST_W'(mag);
    return en ? ext + acc : ext;
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SRC_W-1:0] mag;
    assign mag = abs_diff(src_a[i*SRC_W +: SRC_W], src_b[i*SRC_W +: SRC_W], is_signed);
    assign lane_res[i*DST_W +: DST_W] = fold_acc(mag, acc_in[i*DST_W +: DST_W], op_acc);
  end
endmodule

// File: rtl/abd_operand_sel.sv
module abd_operand_sel #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]   src_a,
  input  logic [VEC_W-1:0]   src_b,
  input  logic               upper_half,
  output logic [VEC_W/2-1:0] half_a,
  output logic [VEC_W/2-1:0] half_b
);
  localparam int HW = VEC_W / 2;
  assign half_a = upper_half ? src_a[VEC_W-1:HW] : src_a[HW-1:0];
  assign half_b = upper_half ? src_b[VEC_W-1:HW] : src_b[HW-1:0];
endmodule

// File: rtl/abd_result_sel.sv
module abd_result_sel
  import simd_abd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [NUM_SZ-1:0][VEC_W-1:0] nar_res,
  input  logic [NUM_SZ-1:0][VEC_W-1:0] wid_res,
  input  logic [1:0]                   lane_sz,
  input  logic                         widen,
  input  logic                         full_width,
  output logic [VEC_W-1:0]             sel_res,
  output logic                         bad_size,
  output logic                         upper_masked
);
  localparam int HW = VEC_W / 2;
  logic [VEC_W-1:0] pick;

  assign bad_size     = (lane_sz == LANE_BAD);
  assign upper_masked = !widen && !full_width;

  always_comb begin
    pick = '0;
    if (!bad_size) pick = widen ? wid_res[lane_sz] : nar_res[lane_sz];
    sel_res = pick;
    if (upper_masked) sel_res[VEC_W-1:HW] = '0;
  end
endmodule

// File: rtl/simd_absdiff_acc.sv
module simd_absdiff_acc
  import simd_abd_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] src_a,
  input  logic [127:0] src_b,
  input  logic [127:0] acc_in,
  input  logic         op_acc,
  input  logic         is_signed,
  input  logic [1:0]   lane_sz,
  input  logic         full_width,
  input  logic         widen,
  input  logic         upper_half,
  output logic         out_valid,
  output logic [127:0] result,
  output logic         illegal
);
  logic [HALF_W-1:0]             half_a, half_b;
  logic [NUM_SZ-1:0][VEC_W-1:0]  nar_res, wid_res;
  logic [VEC_W-1:0]              sel_res;
  logic                          bad_size, upper_masked;

  abd_operand_sel #(.VEC_W(VEC_W)) u_opsel (
    .src_a(src_a), .src_b(src_b), .upper_half(upper_half),
    .half_a(half_a), .half_b(half_b)
  );

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_sz
    localparam int SW = 8 << k;
    abd_lane_bank #(.SRC_W(SW), .DST_W(SW), .LANES(VEC_W/SW)) u_narrow (
      .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
      .is_signed(is_signed), .op_acc(op_acc), .lane_res(nar_res[k])
    );
    abd_lane_bank #(.SRC_W(SW), .DST_W(2*SW), .LANES(HALF_W/SW)) u_wide (
      .src_a(half_a), .src_b(half_b), .acc_in(acc_in),
      .is_signed(is_signed), .op_acc(op_acc), .lane_res(wid_res[k])
    );
  end

  abd_result_sel #(.VEC_W(VEC_W)) u_rsel (
    .nar_res(nar_res), .wid_res(wid_res), .lane_sz(lane_sz),
    .widen(widen), .full_width(full_width),
    .sel_res(sel_res), .bad_size(bad_size), .upper_masked(upper_masked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= bad_size ? '0 : sel_res;
        illegal <= bad_size;
      end
    end
  end

  // R9: output valid is the input valid one clock later
  p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));
  // R9: outputs hold without an accepted operation
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(illegal));
  // R10: unsupported size flags and zeroes the result
  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && lane_sz == 2'd3 |=> illegal && result == '0);
  // R10: legal sizes clear the flag
  p_legal_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && lane_sz != 2'd3 |=> !illegal);
  // R5: 64-bit arrangement leaves the upper half zero
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !widen && !full_width |=> result[127:64] == '0);
  // R1: identical sources with no accumulate give zero
  p_same_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op_acc && src_a == src_b |=> result == '0);
endmodule

// File: tb/simd_absdiff_acc_tb_top.sv
module simd_absdiff_acc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
  logic op_acc = 0, is_signed = 0, full_width = 0, widen = 0, upper_half = 0;
  logic [1:0] lane_sz = 0;
  logic out_valid, illegal;
  logic [127:0] result;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  simd_absdiff_acc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .op_acc(op_acc), .is_signed(is_signed), .lane_sz(lane_sz),
    .full_width(full_width), .widen(widen), .upper_half(upper_half),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  typedef struct packed {
    logic [127:0] a, b, acc;
    logic op, sg;
    logic [1:0] sz;
    logic fw, wd, up;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TBL [NVEC] = '{
    '{128'h7F80_0001_FFFF_8000_1234_EDCB_0000_7FFF, 128'h8000_7FFF_0001_7FFF_EDCB_1234_FFFF_8000, 128'h0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0},
    '{128'hFFFF_FFFF_0000_0001_8000_0000_1234_5678, 128'h0000_0001_FFFF_FFFF_7FFF_FFFF_8765_4321, 128'hFFFF_FFF0_0000_0010_1111_1111_FFFF_FFFF, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0},
    '{128'hDEAD_BEEF_CAFE_F00D_80FF_017F_7E81_00FE, 128'h1111_2222_3333_4444_7F01_FF80_817E_FE00, 128'hAAAA_AAAA_AAAA_AAAA_F0F0_0F0F_FF00_807F, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0},
    '{128'h0102_0304_0506_0708_FF00_80C0_1020_3040, 128'h0807_0605_0403_0201_00FF_4080_2010_4030, 128'hFFFF_0001_8000_7FFF_FFF0_0010_1234_ABCD, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
    '{128'h8000_7FFF_FFFF_0001_5555_AAAA_5555_AAAA, 128'h7FFF_8000_0001_FFFF_AAAA_5555_AAAA_5555, 128'h0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1},
    '{128'h1357_9BDF_2468_ACE0_8000_0000_7FFF_FFFF, 128'h0F0F_0F0F_F0F0_F0F0_7FFF_FFFF_8000_0000, 128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0001, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0},
    '{128'h00FF_00FF_00FF_00FF_FF00_FF00_FF00_FF00, 128'hFF00_FF00_FF00_FF00_00FF_00FF_00FF_00FF, 128'h0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0},
    '{128'hFFFF_FFFF_0000_0000_0000_0000_0000_0000, 128'h0000_0000_FFFF_FFFF_0000_0000_0000_0000, 128'h0000_0000_0000_0001_0000_0000_0000_0000, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1}
  };

  function automatic logic [127:0] model(input vec_t v);
    logic [127:0] r;
    int sw, dw, nl;
    r = '0;
    if (v.sz == 2'd3) return r;
    sw = 8 << v.sz;
    dw = v.wd ? 2 * sw : sw;
    nl = v.wd ? 64 / sw : (v.fw ? 128 : 64) / sw;
    for (int i = 0; i < nl; i++) begin
      logic signed [65:0] xa, xb, d;
      logic [63:0] al, s;
      int sb, rb;
      sb = ((v.wd && v.up) ? 64 : 0) + i * sw;
      rb = i * dw;
      for (int k = 0; k < 66; k++) begin
        xa[k] = (k < sw) ? v.a[sb+k] : (v.sg & v.a[sb+sw-1]);
        xb[k] = (k < sw) ? v.b[sb+k] : (v.sg & v.b[sb+sw-1]);
      end
      d = xa - xb;
      if (d < 0) d = -d;
      al = '0;
      for (int k = 0; k < dw; k++) al[k] = v.acc[rb+k];
      s = d[63:0] + (v.op ? al : 64'd0);
      for (int k = 0; k < dw; k++) r[rb+k] = s[k];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    @(negedge clk);
    src_a = v.a; src_b = v.b; acc_in = v.acc;
    op_acc = v.op; is_signed = v.sg; lane_sz = v.sz;
    full_width = v.fw; widen = v.wd; upper_half = v.up;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic vec_t mk(input logic [127:0] a, b, acc, input logic op, sg,
                              input logic [1:0] sz, input logic fw, wd, up);
    vec_t v;
    v.a = a; v.b = b; v.acc = acc; v.op = op; v.sg = sg;
    v.sz = sz; v.fw = fw; v.wd = wd; v.up = up;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", {127'd0, out_valid}, 128'd0);
    chk("R11 result", result, 128'd0);
    chk("R11 illegal", {127'd0, illegal}, 128'd0);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = TBL[i].wd ? (TBL[i].op ? "R8 table" : "R6 table") : (TBL[i].op ? "R3 table" : "R4 table");
      run_op(TBL[i]);
      chk(tag, result, model(TBL[i]));
      chk("R9 valid", {127'd0, out_valid}, 128'd1);
    end

    // R1 unsigned 8-bit lanes
    run_op(mk(128'hFF05, 128'h010A, 128'h0, 0, 0, 2'd0, 1, 0, 0));
    chk("R1 unsigned diff", result, 128'hFE05);
    // R2 signed vs unsigned
    run_op(mk(128'h80, 128'h7F, 128'h0, 0, 1, 2'd0, 1, 0, 0));
    chk("R2 signed", result, 128'hFF);
    run_op(mk(128'h80, 128'h7F, 128'h0, 0, 0, 2'd0, 1, 0, 0));
    chk("R2 unsigned", result, 128'h01);
    // R3 accumulate wraps
    run_op(mk(128'h20, 128'h0, 128'hF0, 1, 0, 2'd0, 1, 0, 0));
    chk("R3 wrap", result, 128'h10);
    // R5 upper half masked even with accumulate
    run_op(mk({64'hAAAA_AAAA_AAAA_AAAA, 64'h3}, {64'h5555_5555_5555_5555, 64'h1},
              {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, 1, 0, 2'd0, 0, 0, 0));
    chk("R5 upper zero", result, 128'h2);
    // R6 widening signed 32->64 extreme
    run_op(mk(128'h8000_0000, 128'h7FFF_FFFF, 128'h0, 0, 1, 2'd2, 0, 1, 0));
    chk("R6 wide signed", result, 128'hFFFF_FFFF);
    // R7 half select
    run_op(mk({56'h0, 8'h09, 56'h0, 8'h50}, {56'h0, 8'h02, 56'h0, 8'h10}, 128'h0, 0, 0, 2'd0, 0, 1, 1));
    chk("R7 upper", result, 128'h7);
    run_op(mk({56'h0, 8'h09, 56'h0, 8'h50}, {56'h0, 8'h02, 56'h0, 8'h10}, 128'h0, 0, 0, 2'd0, 0, 1, 0));
    chk("R7 lower", result, 128'h40);
    // R8 widening accumulate wraps at 16 bits
    run_op(mk(128'hFF, 128'h00, 128'hFF10, 1, 0, 2'd0, 0, 1, 0));
    chk("R8 wide wrap", result, 128'h000F);
    // R10 illegal size, non-widening and widening
    run_op(mk(128'h1234, 128'h1, 128'h5, 1, 0, 2'd3, 1, 0, 0));
    chk("R10 zero", result, 128'h0);
    chk("R10 flag", {127'd0, illegal}, 128'd1);
    run_op(mk(128'h1234, 128'h1, 128'h5, 0, 1, 2'd3, 0, 1, 1));
    chk("R10 wide flag", {127'd0, illegal}, 128'd1);
    run_op(mk(128'h3, 128'h1, 128'h0, 0, 0, 2'd1, 1, 0, 0));
    chk("R10 clear", {127'd0, illegal}, 128'd0);
    chk("R4 16-bit", result, 128'h2);
    // R9 hold with no valid
    @(negedge clk);
    src_a = '1; lane_sz = 2'd3;
    @(negedge clk);
    chk("R9 no valid", {127'd0, out_valid}, 128'd0);
    chk("R9 hold result", result, 128'h2);
    chk("R9 hold flag", {127'd0, illegal}, 128'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule